// File: doc/BRIEF.md
# Direct-Sequence Spreading BPSK Transmitter

This block turns a slow serial data bit into a spread-spectrum BPSK sample stream. A four-stage shift register with XNOR feedback advances once per chip period and produces a pseudo-noise chip stream. A divided-down chip enable sets the chip period, which is `CHIP_DIV` system clocks. Each chip is combined with the current data bit through an XNOR to form the spread chip.

A sine carrier is built from a nine-entry quarter-wave magnitude table. The table is read forwards and backwards and negated as needed to produce a 36-sample cycle. A sample enable fires every `SAMPLE_DIV` clocks. With a 50 MHz clock and `SAMPLE_DIV = 2`, the sample rate is 25 MHz and the carrier is about 694 kHz, which is several times the 100 kHz chip rate. The sign of each carrier sample follows the spread chip, so every change of the spread chip shifts the carrier phase by 180 degrees.

The data source must hold each bit for at least one full code period of 15 chips. All outputs are registered and driven by one clock domain.

Top module: `dsss_bpsk_tx`

## Requirements
- R1: While `rst` is high on a clock edge, every output is zero and the code register is cleared to all zeros, so the first chip after reset is 0.
- R2: The chip enable pulses on clock edges that are multiples of `CHIP_DIV` after reset release. The code register shifts right on the edge after each pulse, with new leftmost bit = XNOR(stage 4, stage 3), where stage 1 is leftmost. `chip_out` is the rightmost stage.
- R3: Starting from reset, the chip stream repeats every 15 chips. It holds exactly 7 ones per period and never shows four ones in a row, so the all-ones lockup state is never entered.
- R4: `spread_out` is registered every clock as XNOR(`data_in`, `chip_out`), both taken at that edge. Data 0 with chip 0 gives 1, 0/1 gives 0, 1/0 gives 0, and 1/1 gives 1.
- R5: `sample_valid` is a one-clock pulse once every `SAMPLE_DIV` clocks. `sample_out` changes only on the edge where `sample_valid` rises.
- R6: The carrier phase steps through 0..35 once per sample enable and wraps. The magnitude at phase k is round(127·|sin((k+0.5)·10°)|). Phases 18..35 carry the negative half cycle. Output is 8-bit two's complement and never -128.
- R7: A spread chip of 1 (the value held before the sample edge) emits the carrier sample as is, and a spread chip of 0 emits its negation. A data change therefore inverts the sample phase on the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 1 | Serial data bit, held at least 15 chip periods |
| chip_out | output | 1 | Pseudo-noise chip |
| spread_out | output | 1 | Data spread by the chip |
| sample_valid | output | 1 | Pulses when a new carrier sample is presented |
| sample_out | output | 8 | Signed BPSK carrier sample |

## Verification
The hardest case to reach is a data edge that falls in the middle of a chip and between two sample enables. That edge has to flip the sample sign exactly one enable later, without disturbing the chip timing. The stimulus holds data for whole code periods, then toggles it at an odd clock offset inside a chip. The per-clock reference model then has to agree on where the inversion lands. Two full code periods of recorded chips are kept to check the period, the balance and the absence of a four-ones run.

// File: rtl/dsss_pkg.sv
package dsss_pkg;
  localparam int SAMP_W   = 8;
  localparam int QTR_LEN  = 9;
  localparam int CYC_LEN  = 4 * QTR_LEN;
  localparam int QIDX_W   = $clog2(QTR_LEN);

  typedef logic signed [SAMP_W-1:0] samp_t;
  typedef logic [SAMP_W-2:0]        mag_t;

  // Half-sample offset quarter wave: 127*sin((k+0.5)*10 deg)
  function automatic mag_t quarter_mag(input logic [QIDX_W-1:0] idx);
    case (idx)
      4'd0:    quarter_mag = 7'd11;
      4'd1:    quarter_mag = 7'd33;
      4'd2:    quarter_mag = 7'd54;
      4'd3:    quarter_mag = 7'd73;
      4'd4:    quarter_mag = 7'd90;
      4'd5:    quarter_mag = 7'd104;
      4'd6:    quarter_mag = 7'd115;
      4'd7:    quarter_mag = 7'd123;
      4'd8:    quarter_mag = 7'd127;
      default: quarter_mag = 7'd0;
    endcase
  endfunction
endpackage

// File: rtl/rate_tick.sv
module rate_tick #(
  parameter int DIV = 500
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == LAST);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  generate
    if (DIV > 1) begin : g_pulse_chk
      // R5
      single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
  parameter int W     = 4,
  parameter int TAP_A = 4,
  parameter int TAP_B = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  output logic chip_o
);
  localparam int IA = W - TAP_A;
  localparam int IB = W - TAP_B;

  logic [W-1:0] state_q;
  logic         fb;

  assign fb     = ~(state_q[IA] ^ state_q[IB]);
  assign chip_o = state_q[0];

  always_ff @(posedge clk) begin
    if (rst)        state_q <= '0;
    else if (adv_i) state_q <= {fb, state_q[W-1:1]};
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(state_q));
  // R3
  no_lockup_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != {W{1'b1}});
endmodule

// File: rtl/bpsk_carrier.sv
module bpsk_carrier
  import dsss_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick_i,
  input  logic  pos_i,
  output logic  valid_o,
  output samp_t sample_o
);
  logic [QIDX_W-1:0] idx_q;
  logic [1:0]        quad_q;
  logic [QIDX_W-1:0] addr;
  mag_t              mag;
  samp_t             mag_s;
  logic              neg;

  assign addr  = quad_q[0] ? QIDX_W'(QTR_LEN - 1) - idx_q : idx_q;
  assign mag   = quarter_mag(addr);
  assign mag_s = {1'b0, mag};
  assign neg   = quad_q[1] ^ ~pos_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      quad_q   <= '0;
      valid_o  <= 1'b0;
      sample_o <= '0;
    end else begin
      valid_o <= tick_i;
      if (tick_i) begin
        sample_o <= neg ? -mag_s : mag_s;
        if (idx_q == QIDX_W'(QTR_LEN - 1)) begin
          idx_q  <= '0;
          quad_q <= quad_q + 1'b1;
        end else begin
          idx_q  <= idx_q + 1'b1;
        end
      end
    end
  end

  // R6
  index_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx_q < QIDX_W'(QTR_LEN));
  // R6
  no_min_code_chk: assert property (@(posedge clk) disable iff (rst)
    sample_o != samp_t'(-128));
  // R5
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(sample_o));
endmodule

// File: rtl/dsss_bpsk_tx.sv
module dsss_bpsk_tx
  import dsss_pkg::*;
#(
  parameter int CHIP_DIV   = 500,
  parameter int SAMPLE_DIV = 2,
  parameter int PN_W       = 4,
  parameter int TAP_A      = 4,
  parameter int TAP_B      = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        data_in,
  output logic        chip_out,
  output logic        spread_out,
  output logic        sample_valid,
  output logic signed [SAMP_W-1:0] sample_out
);
  logic chip_tick;
  logic samp_tick;

  rate_tick #(.DIV(CHIP_DIV)) chip_rate_i (
    .clk(clk), .rst(rst), .tick_o(chip_tick));

  rate_tick #(.DIV(SAMPLE_DIV)) samp_rate_i (
    .clk(clk), .rst(rst), .tick_o(samp_tick));

  pn_lfsr #(.W(PN_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) pn_i (
    .clk(clk), .rst(rst), .adv_i(chip_tick), .chip_o(chip_out));

  always_ff @(posedge clk) begin
    if (rst) spread_out <= 1'b0;
    else     spread_out <= ~(data_in ^ chip_out);
  end

  bpsk_carrier carrier_i (
    .clk(clk), .rst(rst), .tick_i(samp_tick), .pos_i(spread_out),
    .valid_o(sample_valid), .sample_o(sample_out));

  // R2
  chip_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !chip_tick |=> $stable(chip_out));
endmodule

// File: tb/dsss_bpsk_tx_tb_top.sv
module dsss_bpsk_tx_tb_top;
  localparam int CDIV = 500;
  localparam int SDIV = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data_in = 1'b0;
  logic chip_out, spread_out, sample_valid;
  logic signed [7:0] sample_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dsss_bpsk_tx dut_i (
    .clk(clk), .rst(rst), .data_in(data_in), .chip_out(chip_out),
    .spread_out(spread_out), .sample_valid(sample_valid),
    .sample_out(sample_out));

  // Behavioural reference state
  int  m_cc, m_sc, m_lfsr, m_phase, m_sample;
  bit  m_ctk, m_stk, m_spread, m_valid;
  int  chips[$];

  function automatic int carrier_val(int ph);
    real a;
    int  v;
    a = 127.0 * $sin((ph + 0.5) * 3.14159265358979 / 18.0);
    if (a < 0.0) v = -$rtoi(-a + 0.5);
    else         v = $rtoi(a + 0.5);
    return v;
  endfunction

  always @(posedge clk) begin
    int  n_lfsr, cv;
    bit  chip_old;
    chip_old = m_lfsr[0];
    if (rst) begin
      m_cc = 0; m_sc = 0; m_ctk = 0; m_stk = 0; m_lfsr = 0;
      m_phase = 0; m_sample = 0; m_spread = 0; m_valid = 0;
    end else begin
      if (m_ctk) begin
        n_lfsr = ((((m_lfsr & 1) == ((m_lfsr >> 1) & 1)) ? 1 : 0) << 3) | (m_lfsr >> 1);
        m_lfsr = n_lfsr;
        chips.push_back(m_lfsr & 1);
      end
      m_valid = m_stk;
      if (m_stk) begin
        cv = carrier_val(m_phase);
        m_sample = m_spread ? cv : -cv;
        m_phase = (m_phase + 1) % 36;
      end
      m_spread = (data_in == chip_old);
      m_ctk = (m_cc == CDIV - 1);
      m_cc = (m_cc + 1) % CDIV;
      m_stk = (m_sc == SDIV - 1);
      m_sc = (m_sc + 1) % SDIV;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(chip_out == m_lfsr[0], "R2 chip_out", chip_out, m_lfsr[0]);
    chk(spread_out == m_spread, "R4 spread_out", spread_out, m_spread);
    chk(sample_valid == m_valid, "R5 sample_valid", sample_valid, m_valid);
    chk(int'(sample_out) == m_sample, "R6/R7 sample_out", sample_out, m_sample);
  endtask

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    int ones, run1, maxrun;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(chip_out == 0 && spread_out == 0 && sample_valid == 0 && sample_out == 0,
        "R1 reset outputs", {chip_out, spread_out, sample_valid}, 0);
    rst = 1'b0;
    run(15 * CDIV);               // data 0 for a whole code period
    data_in = 1'b1;
    run(15 * CDIV);               // data 1
    run(CDIV / 2 + 3);
    data_in = 1'b0;               // mid-chip, odd offset: R7 inversion point
    run(7 * CDIV + 1);
    data_in = 1'b1;
    run(3 * CDIV);
    // R3: period, balance, lockup
    chk(chips.size() >= 30, "R3 chip count", chips.size(), 30);
    for (int k = 0; k + 15 < chips.size(); k++)
      chk(chips[k] == chips[k + 15], "R3 period 15", chips[k + 15], chips[k]);
    ones = 0;
    for (int k = 0; k < 15; k++) ones += chips[k];
    chk(ones == 7, "R3 ones per period", ones, 7);
    run1 = 0; maxrun = 0;
    for (int k = 0; k < chips.size(); k++) begin
      run1 = chips[k] ? run1 + 1 : 0;
      if (run1 > maxrun) maxrun = run1;
    end
    chk(maxrun <= 3, "R3 no lockup run", maxrun, 3);
    // R1: reset mid-run clears everything
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    chk(chip_out == 0 && spread_out == 0 && sample_valid == 0 && sample_out == 0,
        "R1 re-reset outputs", {chip_out, spread_out, sample_valid}, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule